// File: doc/BRIEF.md
# Monochrome Bitmap Stream Unpacker

This block sits between a byte source that delivers a stored monochrome bitmap image and a graphic display controller. It receives the image as a byte stream. It drops the fixed-length file preamble and the zero fill that rounds every stored row up to a whole number of 32-bit words. Only the pixel bytes are passed on. Each forwarded byte is tagged with its display row and byte column. The file stores the image bottom row first, so the first forwarded byte is the left end of the lowest display row. The row tag then counts upward through the picture.

The stored image uses 1 for a dark pixel, so every pixel byte is complemented on its way out. A control pin can also mirror the bit order inside each byte, for controllers that shift pixels in the opposite direction. Image width, height and preamble length are elaboration-time parameters. A synchronous restart pin returns the block to preamble skipping, ready for the next image.

Both stream sides use a valid/ready handshake, and a byte moves when valid and ready are both high at a clock edge. Preamble and fill bytes are taken unconditionally. A pixel byte is offered combinationally on the output, and the input is only taken when the output side accepts it. Output back-pressure therefore stalls the source directly, and no byte is held inside the block.

Top module: `mono_raster_unpacker`

## Requirements
- R1: After reset or restart, the first HDR_BYTES input bytes (62 by default) are taken with in_ready high and produce no output (out_valid low).
- R2: The first byte after the preamble is forwarded with out_row = HEIGHT-1 and out_col = 0, the left end of the bottom display row.
- R3: Each stored row holds ceil(WIDTH/8) pixel bytes, forwarded with out_col counting 0 upward. These are followed by (4 - ceil(WIDTH/8) mod 4) mod 4 fill bytes, which are taken with in_ready high and no output. The next byte goes to out_col 0 of the row with out_row one lower.
- R4: With rev_bits low, out_data is the bitwise complement of in_data.
- R5: With rev_bits high, out_data bit i is the complement of in_data bit 7-i.
- R6: While a pixel byte is due, out_valid equals in_valid and in_ready equals out_ready. A byte stalled by out_ready low stays on the output with the same tags, and is neither lost nor repeated.
- R7: Once the fill of the HEIGHT-th stored row is taken (or its last pixel byte, when the row has no fill), frame_done is high for exactly the next cycle. From then until restart, in_ready and out_valid stay low.
- R8: While restart is high, in_ready and out_valid are low. On the next edge the preamble count and the row and column positions return to their start.
- R9: After reset is released, in_ready is high and out_valid and frame_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to preamble skipping |
| rev_bits | input | 1 | Mirror bit order of each forwarded byte |
| in_valid | input | 1 | Input byte is offered |
| in_data | input | 8 | Input byte from the image file |
| in_ready | output | 1 | Block takes the offered byte at the edge |
| out_valid | output | 1 | Pixel byte offered to the controller |
| out_ready | input | 1 | Controller takes the pixel byte at the edge |
| out_data | output | 8 | Complemented, optionally mirrored pixel byte |
| out_row | output | ceil(log2(HEIGHT)) | Display row of the pixel byte |
| out_col | output | ceil(log2(ceil(WIDTH/8))) | Byte column within the row |
| frame_done | output | 1 | One-cycle pulse after the final byte of the image |

## Verification
Two events can share a cycle in this block. A row can end, or the image can complete, while output back-pressure is active. A restart can also arrive while a byte is being offered. The bench stalls the controller on the last pixel byte of every row. It judges that the stalled byte keeps its tags, and that fill skipping and the next row tag follow only after the stall clears. It raises restart with a byte offered, both during the preamble and in the middle of the pixels. It checks that the byte is refused and that a whole fresh preamble is then required before the bottom-left pixel byte appears again.

// File: rtl/mru_pkg.sv
package mru_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_PIX  = 2'd1,
    PH_PAD  = 2'd2,
    PH_DONE = 2'd3
  } mru_phase_e;

  function automatic int fill_bytes(input int bytes_per_row);
    return (4 - (bytes_per_row % 4)) % 4;
  endfunction

  function automatic int idx_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/mru_wrap_cnt.sv
module mru_wrap_cnt #(
  parameter int LIMIT = 4,
  parameter int W     = mru_pkg::idx_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (inc) begin
      value <= (value == TOP) ? '0 : value + 1'b1;
    end
  end

endmodule

// File: rtl/mru_pix_xform.sv
module mru_pix_xform #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] raw,
  input  logic              mirror,
  output logic [BYTE_W-1:0] pix
);

  logic [BYTE_W-1:0] lit;
  logic [BYTE_W-1:0] flipped;

  assign lit = ~raw;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_flip
    assign flipped[i] = lit[BYTE_W-1-i];
  end

  assign pix = mirror ? flipped : lit;

endmodule

// File: rtl/mru_seq.sv
module mru_seq
  import mru_pkg::*;
#(
  parameter int HDR_BYTES = 62,
  parameter int BPR       = 30,
  parameter int PAD       = 2,
  parameter int HEIGHT    = 128,
  parameter int COL_W     = idx_width(BPR),
  parameter int ROW_W     = idx_width(HEIGHT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             fwd,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] file_row,
  output logic             frame_done
);

  localparam int HW = idx_width(HDR_BYTES);
  localparam int PW = idx_width(PAD);

  mru_phase_e      phase, phase_nx;
  logic [HW-1:0]   hdr_cnt;
  logic            take;
  logic            hdr_last, col_last, pad_last, row_last;
  logic            row_end;

  always_comb begin
    if (restart) begin
      in_ready = 1'b0;
    end else begin
      unique case (phase)
        PH_HDR:  in_ready = 1'b1;
        PH_PIX:  in_ready = out_ready;
        PH_PAD:  in_ready = 1'b1;
        default: in_ready = 1'b0;
      endcase
    end
  end

  assign take = in_valid & in_ready;
  assign fwd  = (phase == PH_PIX) & ~restart;

  assign hdr_last = (hdr_cnt  == HW'(HDR_BYTES - 1));
  assign col_last = (col      == COL_W'(BPR - 1));
  assign row_last = (file_row == ROW_W'(HEIGHT - 1));

  mru_wrap_cnt #(.LIMIT(HDR_BYTES)) u_hdr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .inc   (take && phase == PH_HDR),
    .value (hdr_cnt)
  );

  mru_wrap_cnt #(.LIMIT(BPR)) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .inc   (take && phase == PH_PIX),
    .value (col)
  );

  if (PAD > 0) begin : g_pad
    logic [PW-1:0] pad_cnt;

    mru_wrap_cnt #(.LIMIT(PAD)) u_pad (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .inc   (take && phase == PH_PAD),
      .value (pad_cnt)
    );

    assign pad_last = (pad_cnt == PW'(PAD - 1));
    assign row_end  = take && (phase == PH_PAD) && pad_last;
  end else begin : g_nopad
    assign pad_last = 1'b1;
    assign row_end  = take && (phase == PH_PIX) && col_last;
  end

  mru_wrap_cnt #(.LIMIT(HEIGHT)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .inc   (row_end),
    .value (file_row)
  );

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_HDR: if (take && hdr_last) phase_nx = PH_PIX;
      PH_PIX: begin
        if (take && col_last) begin
          if (PAD > 0)       phase_nx = PH_PAD;
          else if (row_last) phase_nx = PH_DONE;
          else               phase_nx = PH_PIX;
        end
      end
      PH_PAD: begin
        if (take && pad_last) phase_nx = row_last ? PH_DONE : PH_PIX;
      end
      default: phase_nx = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_HDR;
      frame_done <= 1'b0;
    end else if (restart) begin
      phase      <= PH_HDR;
      frame_done <= 1'b0;
    end else begin
      phase      <= phase_nx;
      frame_done <= row_end && row_last;
    end
  end

endmodule

// File: rtl/mono_raster_unpacker.sv
module mono_raster_unpacker
  import mru_pkg::*;
#(
  parameter int WIDTH     = 240,
  parameter int HEIGHT    = 128,
  parameter int HDR_BYTES = 62,
  localparam int BPR      = (WIDTH + 7) / 8,
  localparam int PAD      = fill_bytes(BPR),
  localparam int COL_W    = idx_width(BPR),
  localparam int ROW_W    = idx_width(HEIGHT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             rev_bits,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic             frame_done
);

  logic             fwd;
  logic [ROW_W-1:0] file_row;

  mru_seq #(
    .HDR_BYTES (HDR_BYTES),
    .BPR       (BPR),
    .PAD       (PAD),
    .HEIGHT    (HEIGHT),
    .COL_W     (COL_W),
    .ROW_W     (ROW_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .fwd        (fwd),
    .col        (out_col),
    .file_row   (file_row),
    .frame_done (frame_done)
  );

  mru_pix_xform #(.BYTE_W(8)) u_xform (
    .raw    (in_data),
    .mirror (rev_bits),
    .pix    (out_data)
  );

  assign out_valid = fwd & in_valid;
  assign out_row   = ROW_W'(HEIGHT - 1) - file_row;

endmodule

// File: rtl/mru_unpack_chk.sv
module mru_unpack_chk #(
  parameter int LAST_COL = 29,
  parameter int COL_W    = 5,
  parameter int ROW_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col,
  input logic             frame_done
);

  logic step;
  assign step = out_valid && out_ready && !restart &&
                (out_col != COL_W'(LAST_COL));

  assert_fwd_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && (in_ready == out_ready)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!in_ready && !out_valid));

  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!in_ready && !out_valid));

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (out_col == COL_W'($past(out_col) + 1'b1)));

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(out_row));

  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_col <= COL_W'(LAST_COL)));

endmodule

bind mono_raster_unpacker mru_unpack_chk #(
  .LAST_COL (BPR - 1),
  .COL_W    (COL_W),
  .ROW_W    (ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_row    (out_row),
  .out_col    (out_col),
  .frame_done (frame_done)
);

// File: tb/mono_raster_unpacker_tb.sv
module mono_raster_unpacker_tb;

  localparam int WIDTH  = 40;
  localparam int HEIGHT = 3;
  localparam int HDR    = 62;
  localparam int BPR    = 5;
  localparam int PAD    = 3;
  localparam int COL_W  = 3;
  localparam int ROW_W  = 2;
  localparam int NPIX   = BPR * HEIGHT;

  // {rev_bits, file byte} per pixel byte, stored order
  localparam logic [8:0] VEC [0:NPIX-1] = '{
    9'h0FF, 9'h100, 9'h0A5, 9'h181, 9'h03C,
    9'h1F0, 9'h001, 9'h17E, 9'h0C3, 9'h112,
    9'h080, 9'h1E7, 9'h05A, 9'h101, 9'h0F0
  };

  logic             clk = 1'b0;
  logic             rst_n, restart, rev_bits, in_valid, out_ready;
  logic [7:0]       in_data;
  logic             in_ready, out_valid, frame_done;
  logic [7:0]       out_data;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mono_raster_unpacker #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .HDR_BYTES(HDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rev_bits(rev_bits),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_row(out_row), .out_col(out_col), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] want_px(input logic [8:0] v);
    logic [7:0] inv, r;
    inv = ~v[7:0];
    for (int i = 0; i < 8; i++) r[i] = inv[7-i];
    return v[8] ? r : inv;
  endfunction

  task automatic drive(input logic [7:0] d, input bit rv, input bit ordy);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    rev_bits  = rv;
    out_ready = ordy;
    #2;
  endtask

  task automatic skip_byte(input logic [7:0] d, input string req);
    drive(d, 1'b0, 1'b1);
    chk(in_ready == 1'b1, {req, " in_ready"}, in_ready, 1);
    chk(out_valid == 1'b0, {req, " out_valid"}, out_valid, 0);
    @(posedge clk);
  endtask

  task automatic pix_byte(input int idx, input int row, input int col, input bit stall);
    string rq;
    rq = (idx == 0) ? "R2" : "R3";
    if (stall) begin
      for (int s = 0; s < 2; s++) begin
        drive(VEC[idx][7:0], VEC[idx][8], 1'b0);
        chk(in_ready == 1'b0, "R6 stall in_ready", in_ready, 0);
        chk(out_valid == 1'b1 && out_col == COL_W'(col), "R6 stall hold", out_col, col);
        @(posedge clk);
      end
    end
    drive(VEC[idx][7:0], VEC[idx][8], 1'b1);
    chk(out_valid == 1'b1 && in_ready == 1'b1, "R6 pass", out_valid, 1);
    chk(out_row == ROW_W'(row), {rq, " row"}, out_row, row);
    chk(out_col == COL_W'(col), {rq, " col"}, out_col, col);
    chk(out_data == want_px(VEC[idx]), VEC[idx][8] ? "R5 data" : "R4 data",
        out_data, want_px(VEC[idx]));
    @(posedge clk);
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart  = 1'b1;
    in_valid = 1'b1;
    in_data  = 8'h11;
    #2;
    chk(in_ready == 1'b0, "R8 in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    restart  = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic frame(input bit stall_row_end);
    for (int h = 0; h < HDR; h++) skip_byte(8'(h), "R1");
    for (int r = 0; r < HEIGHT; r++) begin
      for (int c = 0; c < BPR; c++)
        pix_byte(r * BPR + c, HEIGHT - 1 - r, c, stall_row_end && (c == BPR - 1));
      for (int p = 0; p < PAD; p++) skip_byte(8'h00, "R3 fill");
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h55;
    #2;
    chk(frame_done == 1'b1, "R7 pulse", frame_done, 1);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R7 idle", in_ready, 0);
    @(negedge clk);
    #2;
    chk(frame_done == 1'b0, "R7 single", frame_done, 0);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R7 held", in_ready, 0);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; rev_bits = 1'b0;
    in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(frame_done == 1'b0, "R9 frame_done", frame_done, 0);

    frame(1'b0);
    do_restart();
    frame(1'b1);

    // restart during preamble with a byte offered
    do_restart();
    for (int h = 0; h < 30; h++) skip_byte(8'hEE, "R1");
    do_restart();
    frame(1'b0);

    // restart in the middle of the pixels
    do_restart();
    for (int h = 0; h < HDR; h++) skip_byte(8'h22, "R1");
    pix_byte(0, HEIGHT - 1, 0, 1'b0);
    pix_byte(1, HEIGHT - 1, 1, 1'b0);
    do_restart();
    frame(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule